// File: doc/BRIEF.md
# Segment Relocation and Limit Check Unit

This block turns an effective address into a physical one for a machine that uses segmented addressing. Every reference carries a two-bit segment number, a 32-bit effective address and a flag that marks it as an instruction fetch or a data access. The flag picks one of two separate register sets, one for fetches and one for data. The segment number picks a base/limit pair from that set. The unit adds the base to the effective address and compares the sum with the limit. One cycle later it reports the physical address and either a pass or a fault.

The base and limit registers change only through a write port that carries a supervisor flag. A write without the flag is discarded and raises a one-cycle error pulse. After reset every base and limit is zero, so every reference faults until the supervisor loads the registers. A new reference can be accepted on every cycle.

Top module: `seg_xlate_unit`

## Requirements
- R1: When `req_valid` is high at a clock edge, `rsp_valid` is high after that edge and `rsp_pa` holds the low 32 bits of `req_ea` plus the selected base. Without a request, `rsp_valid`, `rsp_ok` and `rsp_fault` are low after the edge.
- R2: A response passes (`rsp_ok`=1, `rsp_fault`=0) only when the physical address is strictly below the selected limit. A response at or above the limit faults (`rsp_ok`=0, `rsp_fault`=1).
- R3: If the sum of base and effective address carries out of bit 31, the response faults whatever the limit is.
- R4: When `req_is_fetch`=1 the unit uses the fetch register set, and when it is 0 it uses the data set. A write reaches the fetch set when `wr_is_fetch`=1 and the data set when it is 0.
- R5: `req_seg` selects the pair with that index (0 to 3) in the chosen set, and `wr_seg` selects the pair a write targets.
- R6: A write with `wr_en`=1 and `wr_priv`=1 stores `wr_data` into the limit of the addressed pair when `wr_is_bound`=1, or into its base when `wr_is_bound`=0. The new value takes effect from the next edge on. A request in the same cycle as the write still uses the old value.
- R7: A write with `wr_en`=1 and `wr_priv`=0 changes no register. `wr_priv_err` is high for exactly the cycle after that attempt, and it is low after every other edge.
- R8: After reset all bases and limits are zero, so every reference faults, and `rsp_valid` and `wr_priv_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A reference is presented this cycle |
| req_is_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| req_seg | input | 2 | Segment number of the reference |
| req_ea | input | 32 | Effective address |
| rsp_valid | output | 1 | Registered response is present |
| rsp_pa | output | 32 | Relocated physical address |
| rsp_ok | output | 1 | Reference is within its segment |
| rsp_fault | output | 1 | Reference violates its segment |
| wr_en | input | 1 | Register write request |
| wr_priv | input | 1 | Writer is in supervisor mode |
| wr_is_fetch | input | 1 | Write targets the fetch set (1) or the data set (0) |
| wr_is_bound | input | 1 | Write targets the limit (1) or the base (0) |
| wr_seg | input | 2 | Segment pair the write targets |
| wr_data | input | 32 | Value to store |
| wr_priv_err | output | 1 | One-cycle pulse after a dropped unprivileged write |

## Verification
The bench tests the limit comparison at the limit and one below it. A design that used less-or-equal would pass an address equal to the limit. It forces sums that carry out of 32 bits against a maximal limit, where a design that dropped the carry would pass a wrapped address. It sends same-cycle writes and requests, along with fetch and data references to the same segment number, to expose a design that forwards new values early or mixes up the two sets. It also sends unprivileged writes and then reads the targeted pair back, which catches a design that lets the write through or pulses the error on the wrong cycle.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned NUM_SEG = 4;
    localparam int unsigned SEG_W   = $clog2(NUM_SEG);

    typedef enum logic {
        SET_DATA  = 1'b0,
        SET_FETCH = 1'b1
    } seg_set_e;

    typedef enum logic {
        FLD_BASE  = 1'b0,
        FLD_LIMIT = 1'b1
    } seg_field_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_xlate_pkg::*;
#(
    parameter int unsigned NSEG = NUM_SEG,
    parameter int unsigned AW   = ADDR_W,
    localparam int unsigned SW  = $clog2(NSEG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  seg_field_e    wr_field,
    input  logic [SW-1:0] wr_seg,
    input  logic [AW-1:0] wr_data,
    input  logic [SW-1:0] rd_seg,
    output logic [AW-1:0] rd_base,
    output logic [AW-1:0] rd_limit
);
    logic [NSEG-1:0][AW-1:0] base_q;
    logic [NSEG-1:0][AW-1:0] limit_q;

    for (genvar s = 0; s < NSEG; s++) begin : g_pair
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[s]  <= '0;
                limit_q[s] <= '0;
            end else if (wr_en && (wr_seg == SW'(s))) begin
                if (wr_field == FLD_LIMIT) limit_q[s] <= wr_data;
                else                       base_q[s]  <= wr_data;
            end
        end
    end

    assign rd_base  = base_q[rd_seg];
    assign rd_limit = limit_q[rd_seg];

    // R7: without a gated write the table holds still
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(base_q) && $stable(limit_q)));
endmodule

// File: rtl/seg_check.sv
module seg_check #(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] ea,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    output logic [AW-1:0] pa,
    output logic          carry,
    output logic          in_range
);
    logic [AW:0] sum;

    always_comb begin
        sum      = {1'b0, ea} + {1'b0, base};
        pa       = sum[AW-1:0];
        carry    = sum[AW];
        in_range = !carry && (sum[AW-1:0] < limit);
    end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_is_fetch,
    input  logic [1:0]  req_seg,
    input  logic [31:0] req_ea,
    output logic        rsp_valid,
    output logic [31:0] rsp_pa,
    output logic        rsp_ok,
    output logic        rsp_fault,
    input  logic        wr_en,
    input  logic        wr_priv,
    input  logic        wr_is_fetch,
    input  logic        wr_is_bound,
    input  logic [1:0]  wr_seg,
    input  logic [31:0] wr_data,
    output logic        wr_priv_err
);
    localparam int unsigned NSETS = 2;

    logic [NSETS-1:0][ADDR_W-1:0] set_base;
    logic [NSETS-1:0][ADDR_W-1:0] set_limit;
    logic [ADDR_W-1:0] sel_base, sel_limit, pa_d;
    logic              carry_d, in_range_d;
    seg_field_e        field;

    assign field = wr_is_bound ? FLD_LIMIT : FLD_BASE;

    for (genvar g = 0; g < NSETS; g++) begin : g_set
        logic set_wr;
        assign set_wr = wr_en && wr_priv && (wr_is_fetch == g[0]);
        seg_regfile #(.NSEG(NUM_SEG), .AW(ADDR_W)) u_tbl (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (set_wr),
            .wr_field (field),
            .wr_seg   (wr_seg),
            .wr_data  (wr_data),
            .rd_seg   (req_seg),
            .rd_base  (set_base[g]),
            .rd_limit (set_limit[g])
        );
    end

    always_comb begin
        unique case (seg_set_e'(req_is_fetch))
            SET_FETCH: begin sel_base = set_base[1]; sel_limit = set_limit[1]; end
            SET_DATA:  begin sel_base = set_base[0]; sel_limit = set_limit[0]; end
        endcase
    end

    seg_check #(.AW(ADDR_W)) u_chk (
        .ea       (req_ea),
        .base     (sel_base),
        .limit    (sel_limit),
        .pa       (pa_d),
        .carry    (carry_d),
        .in_range (in_range_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_pa      <= '0;
            rsp_ok      <= 1'b0;
            rsp_fault   <= 1'b0;
            wr_priv_err <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_ok      <= req_valid && in_range_d;
            rsp_fault   <= req_valid && !in_range_d;
            wr_priv_err <= wr_en && !wr_priv;
            if (req_valid) rsp_pa <= pa_d;
        end
    end

    // R1: one response per request, one cycle later
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R2: a response is exactly one of pass or fault
    p_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_ok != rsp_fault));
    // R3: a carry out of the adder always faults
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && carry_d) |=> rsp_fault);
    // R7: dropped write pulses the error flag
    p_priv_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_priv) |=> wr_priv_err);
    p_priv_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !wr_priv) |=> !wr_priv_err);
endmodule

// File: tb/tb_seg_xlate_unit.sv
module tb_seg_xlate_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_is_fetch = 0;
    logic [1:0]  req_seg = 0;
    logic [31:0] req_ea = 0;
    logic        rsp_valid, rsp_ok, rsp_fault, wr_priv_err;
    logic [31:0] rsp_pa;
    logic        wr_en = 0, wr_priv = 0, wr_is_fetch = 0, wr_is_bound = 0;
    logic [1:0]  wr_seg = 0;
    logic [31:0] wr_data = 0;

    int errors = 0;
    int checks = 0;
    logic [31:0] m_base  [2][4];
    logic [31:0] m_limit [2][4];

    always #2 clk = ~clk;

    seg_xlate_unit dut (.*);

    function automatic logic [32:0] exp_sum(input logic f, input logic [1:0] s, input logic [31:0] ea);
        return {1'b0, ea} + {1'b0, m_base[f][s]};
    endfunction

    function automatic logic exp_ok(input logic f, input logic [1:0] s, input logic [31:0] ea);
        logic [32:0] t;
        t = exp_sum(f, s, ea);
        return !t[32] && (t[31:0] < m_limit[f][s]);
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic rv, input logic rf, input logic [1:0] rs, input logic [31:0] ea,
                        input logic we, input logic wp, input logic wf, input logic wb,
                        input logic [1:0] ws, input logic [31:0] wd, input string tag);
        logic [32:0] s;
        logic        ok;
        @(negedge clk);
        req_valid = rv; req_is_fetch = rf; req_seg = rs; req_ea = ea;
        wr_en = we; wr_priv = wp; wr_is_fetch = wf; wr_is_bound = wb; wr_seg = ws; wr_data = wd;
        s  = exp_sum(rf, rs, ea);
        ok = exp_ok(rf, rs, ea);
        @(posedge clk);
        #1;
        if (we && wp) begin
            if (wb) m_limit[wf][ws] = wd;
            else    m_base[wf][ws]  = wd;
        end
        chk("R1", "rsp_valid", {31'b0, rsp_valid}, {31'b0, rv});
        if (rv) begin
            chk("R1", "rsp_pa", rsp_pa, s[31:0]);
            chk(s[32] ? "R3" : tag, "rsp_ok", {31'b0, rsp_ok}, {31'b0, ok});
            chk(s[32] ? "R3" : tag, "rsp_fault", {31'b0, rsp_fault}, {31'b0, !ok});
        end else begin
            chk("R1", "idle rsp_ok|fault", {30'b0, rsp_ok, rsp_fault}, 32'd0);
        end
        chk("R7", "wr_priv_err", {31'b0, wr_priv_err}, {31'b0, we && !wp});
    endtask

    task automatic pwrite(input logic f, input logic b, input logic [1:0] s, input logic [31:0] d);
        step(0, 0, 0, 0, 1, 1, f, b, s, d, "R6");
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int f = 0; f < 2; f++)
            for (int s = 0; s < 4; s++) begin m_base[f][s] = 0; m_limit[f][s] = 0; end
        repeat (3) @(posedge clk);
        #1;
        chk("R8", "reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
        chk("R8", "reset wr_priv_err", {31'b0, wr_priv_err}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        // R8: zero limits fault everything, including address 0
        step(1, 0, 0, 32'h0, 0, 0, 0, 0, 0, 0, "R8");
        step(1, 1, 3, 32'h10, 0, 0, 0, 0, 0, 0, "R8");
        // R6: load pairs in both sets, distinct per set and segment (R4, R5)
        for (int f = 0; f < 2; f++)
            for (int s = 0; s < 4; s++) begin
                pwrite(f[0], 0, s[1:0], 32'h1000_0000 * (f + 1) + 32'h100 * s);
                pwrite(f[0], 1, s[1:0], 32'h1000_0000 * (f + 1) + 32'h100 * s + 32'h80);
            end
        // R4/R5: same seg, different sets, different results
        step(1, 0, 2, 32'h7F, 0, 0, 0, 0, 0, 0, "R4");
        step(1, 1, 2, 32'h7F, 0, 0, 0, 0, 0, 0, "R4");
        step(1, 1, 1, 32'h40, 0, 0, 0, 0, 0, 0, "R5");
        // R2: limit-1 passes, limit faults
        step(1, 0, 0, 32'h7F, 0, 0, 0, 0, 0, 0, "R2");
        step(1, 0, 0, 32'h80, 0, 0, 0, 0, 0, 0, "R2");
        // R3: carry with maximal limit
        pwrite(1, 1, 3, 32'hFFFF_FFFF);
        step(1, 1, 3, 32'hF000_0000, 0, 0, 0, 0, 0, 0, "R3");
        // R6: same-cycle write and request sees old value, then new one
        step(1, 0, 1, 32'h10, 1, 1, 0, 1, 1, 32'h0, "R6");
        step(1, 0, 1, 32'h10, 0, 0, 0, 0, 0, 0, "R6");
        // R7: unprivileged write dropped; pair read back unchanged
        step(0, 0, 0, 0, 1, 0, 1, 0, 0, 32'hDEAD_0000, "R7");
        step(1, 1, 0, 32'h20, 0, 0, 0, 0, 0, 0, "R7");
        step(1, 1, 0, 32'h20, 1, 0, 1, 1, 0, 32'h0, "R7");
        step(1, 1, 0, 32'h20, 0, 0, 0, 0, 0, 0, "R7");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], r[1], r[3:2], (r[4] ? $urandom : ($urandom & 32'h0000_FFFF)),
                 (r[7:5] == 0), r[8], r[9], r[10], r[12:11],
                 (r[13] ? $urandom : ($urandom & 32'h0001_FFFF)), "R2");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule